// File: doc/BRIEF.md
# Spindle Start-Up Mode Sequencer

This block is the mode controller for a three-phase sensorless spindle motor. It decides whether the bridge is floated, braked or driven. When driven, it picks which phase sources current and which sinks it, by stepping a six-position commutation counter. It takes the run/brake and output-enable controls, a sequence-step strobe and a sequence-reset strobe. It also takes the auto/external start selection, single-cycle zero-crossing events from the back-EMF comparator, and a tick derived from the speed reference. From these it produces per-phase high-side and low-side enables together with status flags.

In automatic start, a rising run/brake edge energises position 1. After a first delay counted in reference ticks, the block jumps two positions to 3. After a second delay it jumps two more to 5 and enters go, where every zero crossing advances the position by one. Two supervisors watch go mode:
- If no crossing arrives within a fixed number of clocks, the block floats the bridge and clears the stuck-rotor flag.
- If the crossing interval suddenly stretches, the block sets the reverse/slowdown flag and brakes.

An alternative path disables auto start and lets an external controller step the bridge by hand. This path is chosen by strobing the step input while the block idles with both controls low, or by clearing the auto selection.

The named states are:
- HOLD: idle, braking when enabled.
- ALIGN1: position 1.
- ALIGN2: position 3.
- GO: closed-loop commutation.
- STUCK: floated after the no-crossing timeout.
- REVBRK: braked after a supervisor fault.
- EXT: hand-stepped.

Transitions:
- HOLD→ALIGN1 or HOLD→EXT: run/brake rise while enabled.
- ALIGN1→ALIGN2: first delay done.
- ALIGN2→GO: second delay done.
- GO→STUCK: no-crossing timeout.
- GO→REVBRK: slowdown detected.
- Any of ALIGN1, ALIGN2, GO or EXT → HOLD: run/brake low or enable low.
- STUCK→HOLD and REVBRK→HOLD: run/brake low.

Top module: `spin_start_seq`

## Requirements
- R1: While `out_en` is 0, `tristate` is 1 and every `high_on` and `low_on` bit is 0. Dropping `out_en` in ALIGN1, ALIGN2, GO or EXT returns the machine to HOLD.
- R2: In HOLD or REVBRK with `out_en` 1, `brake` is 1, `low_on` is 3'b111 and `high_on` is 3'b000. Dropping `run_brake` in any state returns to HOLD.
- R3: A `run_brake` 0→1 edge in HOLD, with `out_en` 1, `auto_mode` 1 and auto start not disabled, enters ALIGN1 at position 1 with `align_flag`=0 and `go_flag`=0. `seq_inc` has no effect on the position during ALIGN1 and ALIGN2.
- R4: With total = BASE_TICKS*(dly_sel+1), ALIGN1 lasts total/4 `ref_tick` pulses. The position then steps by two to 3, and `align_flag` becomes 1.
- R5: ALIGN2 lasts total − total/4 `ref_tick` pulses. The position then steps by two to 5, and `go_flag` becomes 1.
- R6: In GO, each `zc_evt` pulse advances the position by one, with 6 wrapping to 1.
- R7: If no `zc_evt` arrives within STUCK_CYCLES clocks of entering GO, the block enters STUCK. There `tristate` is 1, `stuck_ok` drops to 0, and the state holds until `run_brake` goes low. `stuck_ok` returns to 1 on the next ALIGN1 entry.
- R8: In GO, once two crossings have been seen, the block checks the current interval against the last full one. If the current interval exceeds twice the last, `rev_fault` becomes 1 and the block enters REVBRK (braking). `rev_fault` clears on the next ALIGN1 entry.
- R9: A `seq_inc` of 1 in HOLD with `run_brake` and `out_en` both 0 disables auto start until reset. While auto start is disabled, or while `auto_mode` is 0, the start edge enters EXT instead of ALIGN1.
- R10: In EXT, each `seq_inc` 0→1 edge advances the position by one. A `zc_evt` advances it only while `seq_inc` is 0.
- R11: `seq_reset` returns the position to 1 in any state other than ALIGN1 and ALIGN2, taking priority over any step in the same cycle.
- R12: The driven pair follows the position as high→low phase: 1 A→B, 2 A→C, 3 B→C, 4 B→A, 5 C→A, 6 C→B. Bit 0 of `high_on` and `low_on` is phase A, bit 1 is B and bit 2 is C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_brake | input | 1 | 1 = run, 0 = brake; a rising edge starts a spin-up |
| out_en | input | 1 | Bridge enable; 0 floats all outputs |
| seq_inc | input | 1 | Manual step strobe / zero-crossing mask |
| auto_mode | input | 1 | 1 selects automatic start |
| seq_reset | input | 1 | Returns the position to 1 |
| zc_evt | input | 1 | One-cycle back-EMF zero-crossing event |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| dly_sel | input | 2 | Alignment total-delay select |
| phase | output | 3 | Commutation position, 1 to 6 |
| high_on | output | 3 | High-side enables, bit 0 = phase A |
| low_on | output | 3 | Low-side enables, bit 0 = phase A |
| brake | output | 1 | Braking command |
| tristate | output | 1 | Bridge floated |
| align_flag | output | 1 | Second alignment step reached |
| go_flag | output | 1 | Closed-loop commutation active |
| stuck_ok | output | 1 | 0 after a stuck-rotor timeout |
| rev_fault | output | 1 | 1 after reverse/slowdown detection |

## Verification
The slowdown fault is the hardest case to reach. It needs a full automatic alignment, then two crossings spaced closely enough to set a short reference interval, then a gap long enough to exceed twice that interval. The bench reaches it by reducing the tick-based delays through parameters. It then places the two crossings about nine clocks apart and probes once inside the tolerance and once well beyond it. The stuck timeout is reached the same way, from a fresh start in which no crossing is given at all.

// File: rtl/spin_pkg.sv
package spin_pkg;

    typedef enum logic [2:0] {
        M_HOLD,
        M_ALIGN1,
        M_ALIGN2,
        M_GO,
        M_STUCK,
        M_REVBRK,
        M_EXT
    } mode_e;

    // Returns {high[2:0], low[2:0]}; bit 0 = phase A, bit 1 = B, bit 2 = C.
    function automatic logic [5:0] phase_drive(input logic [2:0] pos);
        logic [5:0] d;
        unique case (pos)
            3'd1:    d = {3'b001, 3'b010};
            3'd2:    d = {3'b001, 3'b100};
            3'd3:    d = {3'b010, 3'b100};
            3'd4:    d = {3'b010, 3'b001};
            3'd5:    d = {3'b100, 3'b001};
            3'd6:    d = {3'b100, 3'b010};
            default: d = 6'b000000;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/spin_comm_seq.sv
module spin_comm_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load1,
    input  logic       step,
    input  logic       dstep,
    output logic [2:0] pos
);
    function automatic logic [2:0] advance(input logic [2:0] p, input logic [1:0] k);
        logic [3:0] s;
        s = {1'b0, p} + {2'b00, k};
        return (s > 4'd6) ? 3'(s - 4'd6) : s[2:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pos <= 3'd1;
        else if (load1) pos <= 3'd1;
        else if (dstep) pos <= advance(pos, 2'd2);
        else if (step)  pos <= advance(pos, 2'd1);
    end
endmodule

// File: rtl/spin_align_timer.sv
module spin_align_timer #(
    parameter int BASE_TICKS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       tick,
    input  logic       second,
    input  logic [1:0] dsel,
    output logic       done
);
    localparam int CNT_W = $clog2(BASE_TICKS * 4 + 1) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] total, t_first, t_second, limit;

    always_comb begin
        total    = CNT_W'(BASE_TICKS) * (CNT_W'(dsel) + CNT_W'(1));
        t_first  = total >> 2;
        t_second = total - t_first;
        limit    = second ? t_second : t_first;
        done     = en && (cnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (clr)                 cnt <= '0;
        else if (en && tick && !done) cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/spin_zc_watch.sv
module spin_zc_watch #(
    parameter int STUCK_CYCLES = 4_190_000,
    parameter int IVL_W        = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic zc,
    output logic stuck,
    output logic slowdown
);
    localparam int ST_W = $clog2(STUCK_CYCLES + 1);

    logic [ST_W-1:0]  st_cnt;
    logic [IVL_W-1:0] ivl, prev;
    logic             seen1, seen2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_cnt <= '0; ivl <= '0; prev <= '0; seen1 <= 1'b0; seen2 <= 1'b0;
        end else if (!en) begin
            st_cnt <= '0; ivl <= '0; prev <= '0; seen1 <= 1'b0; seen2 <= 1'b0;
        end else begin
            if (zc) begin
                seen1 <= 1'b1;
                ivl   <= '0;
                if (seen1) begin
                    prev  <= ivl;
                    seen2 <= 1'b1;
                end
            end else if (!(&ivl)) begin
                ivl <= ivl + IVL_W'(1);
            end
            if (!seen1 && st_cnt != ST_W'(STUCK_CYCLES))
                st_cnt <= st_cnt + ST_W'(1);
        end
    end

    assign stuck    = en && !seen1 && (st_cnt == ST_W'(STUCK_CYCLES));
    assign slowdown = en && seen2 && ({1'b0, ivl} > {prev, 1'b0});
endmodule

// File: rtl/spin_start_seq.sv
module spin_start_seq #(
    parameter int BASE_TICKS   = 64,
    parameter int STUCK_CYCLES = 4_190_000,
    parameter int IVL_W        = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_brake,
    input  logic       out_en,
    input  logic       seq_inc,
    input  logic       auto_mode,
    input  logic       seq_reset,
    input  logic       zc_evt,
    input  logic       ref_tick,
    input  logic [1:0] dly_sel,
    output logic [2:0] phase,
    output logic [2:0] high_on,
    output logic [2:0] low_on,
    output logic       brake,
    output logic       tristate,
    output logic       align_flag,
    output logic       go_flag,
    output logic       stuck_ok,
    output logic       rev_fault
);
    import spin_pkg::*;

    mode_e mode_q, mode_d;
    logic  rb_q, si_q, ext_lock;
    logic  load1, step, dstep;
    logic  t_done, stuck_to, slow_det;
    logic  rb_rise, si_rise, in_align, leave_run;
    logic [5:0] drv;

    assign rb_rise   = run_brake && !rb_q;
    assign si_rise   = seq_inc && !si_q;
    assign in_align  = (mode_q == M_ALIGN1) || (mode_q == M_ALIGN2);
    assign leave_run = !run_brake || !out_en;

    // next-state logic
    always_comb begin
        mode_d = mode_q;
        load1  = 1'b0;
        step   = 1'b0;
        dstep  = 1'b0;
        unique case (mode_q)
            M_HOLD: begin
                if (rb_rise && out_en) begin
                    if (auto_mode && !ext_lock) begin
                        mode_d = M_ALIGN1;
                        load1  = 1'b1;
                    end else begin
                        mode_d = M_EXT;
                    end
                end
            end
            M_ALIGN1: begin
                if (leave_run)   mode_d = M_HOLD;
                else if (t_done) begin mode_d = M_ALIGN2; dstep = 1'b1; end
            end
            M_ALIGN2: begin
                if (leave_run)   mode_d = M_HOLD;
                else if (t_done) begin mode_d = M_GO; dstep = 1'b1; end
            end
            M_GO: begin
                if (leave_run)     mode_d = M_HOLD;
                else if (slow_det) mode_d = M_REVBRK;
                else if (stuck_to) mode_d = M_STUCK;
                else               step   = zc_evt;
            end
            M_STUCK, M_REVBRK: begin
                if (!run_brake) mode_d = M_HOLD;
            end
            M_EXT: begin
                if (leave_run) mode_d = M_HOLD;
                else           step   = si_rise || (zc_evt && !seq_inc);
            end
            default: mode_d = M_HOLD;
        endcase
        if (seq_reset && !in_align) begin
            load1 = 1'b1;
            step  = 1'b0;
            dstep = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= M_HOLD;
            rb_q      <= 1'b0;
            si_q      <= 1'b0;
            ext_lock  <= 1'b0;
            stuck_ok  <= 1'b1;
            rev_fault <= 1'b0;
        end else begin
            mode_q <= mode_d;
            rb_q   <= run_brake;
            si_q   <= seq_inc;
            if (mode_q == M_HOLD && !out_en && !run_brake && seq_inc)
                ext_lock <= 1'b1;
            if (mode_d == M_ALIGN1 && mode_q == M_HOLD) begin
                stuck_ok  <= 1'b1;
                rev_fault <= 1'b0;
            end else begin
                if (mode_q == M_GO && mode_d == M_STUCK)  stuck_ok  <= 1'b0;
                if (mode_q == M_GO && mode_d == M_REVBRK) rev_fault <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        drv        = phase_drive(phase);
        tristate   = !out_en || (mode_q == M_STUCK);
        brake      = out_en && ((mode_q == M_HOLD) || (mode_q == M_REVBRK));
        high_on    = (tristate || brake) ? 3'b000 : drv[5:3];
        low_on     = tristate ? 3'b000 : (brake ? 3'b111 : drv[2:0]);
        align_flag = (mode_q == M_ALIGN2) || (mode_q == M_GO);
        go_flag    = (mode_q == M_GO);
    end

    spin_comm_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load1 (load1),
        .step  (step),
        .dstep (dstep),
        .pos   (phase)
    );

    spin_align_timer #(.BASE_TICKS(BASE_TICKS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (mode_d != mode_q),
        .en     (in_align),
        .tick   (ref_tick),
        .second (mode_q == M_ALIGN2),
        .dsel   (dly_sel),
        .done   (t_done)
    );

    spin_zc_watch #(.STUCK_CYCLES(STUCK_CYCLES), .IVL_W(IVL_W)) u_zcw (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mode_q == M_GO),
        .zc       (zc_evt),
        .stuck    (stuck_to),
        .slowdown (slow_det)
    );
endmodule

// File: rtl/spin_start_seq_chk.sv
module spin_start_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       out_en,
    input logic       zc_evt,
    input logic       seq_reset,
    input logic [2:0] phase,
    input logic [2:0] high_on,
    input logic [2:0] low_on,
    input logic       brake,
    input logic       tristate,
    input logic       align_flag,
    input logic       go_flag,
    input logic       stuck_ok,
    input logic       rev_fault
);
    function automatic logic [2:0] nxt(input logic [2:0] p);
        return (p == 3'd6) ? 3'd1 : p + 3'd1;
    endfunction

    p_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (tristate && high_on == 3'b000 && low_on == 3'b000));

    p_brake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        brake |-> (low_on == 3'b111 && high_on == 3'b000));

    p_second_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(align_flag) |-> phase == 3'd3);

    p_go_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_flag) |-> phase == 3'd5);

    p_zc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go_flag && $past(go_flag) && $past(zc_evt) && !$past(seq_reset))
        |-> phase == nxt($past(phase)));

    p_stuck_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stuck_ok) |-> tristate);

    p_rev_brake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_fault && out_en) |-> brake);

    p_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !brake |-> ($onehot0(high_on) && $onehot0(low_on) && (high_on & low_on) == 3'b000));
endmodule

bind spin_start_seq spin_start_seq_chk u_chk (.*);

// File: tb/spin_start_seq_tb.sv
`timescale 1ns/1ps
module spin_start_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_brake = 1'b0, out_en = 1'b0, seq_inc = 1'b0, auto_mode = 1'b1;
    logic       seq_reset = 1'b0, zc_evt = 1'b0, ref_tick = 1'b0;
    logic [1:0] dly_sel = 2'd0;
    logic [2:0] phase, high_on, low_on;
    logic       brake, tristate, align_flag, go_flag, stuck_ok, rev_fault;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spin_start_seq #(.BASE_TICKS(8), .STUCK_CYCLES(100), .IVL_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_brake(run_brake), .out_en(out_en),
        .seq_inc(seq_inc), .auto_mode(auto_mode), .seq_reset(seq_reset),
        .zc_evt(zc_evt), .ref_tick(ref_tick), .dly_sel(dly_sel),
        .phase(phase), .high_on(high_on), .low_on(low_on), .brake(brake),
        .tristate(tristate), .align_flag(align_flag), .go_flag(go_flag),
        .stuck_ok(stuck_ok), .rev_fault(rev_fault)
    );

    // expected {high,low} per position: A->B, A->C, B->C, B->A, C->A, C->B
    function automatic logic [5:0] exp_pair(input int p);
        case (p)
            1: return 6'b001_010;
            2: return 6'b001_100;
            3: return 6'b010_100;
            4: return 6'b010_001;
            5: return 6'b100_001;
            6: return 6'b100_010;
            default: return 6'b000000;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ref_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic zc_pulse();
        zc_evt = 1'b1; @(negedge clk); zc_evt = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
    endtask

    // {seq_inc, zc_evt, expected phase} for manual stepping, from position 1
    localparam logic [4:0] EXT_VEC [12] = '{
        {1'b1, 1'b0, 3'd2}, {1'b1, 1'b0, 3'd2}, {1'b1, 1'b1, 3'd2},
        {1'b0, 1'b0, 3'd2}, {1'b0, 1'b1, 3'd3}, {1'b1, 1'b0, 3'd4},
        {1'b0, 1'b0, 3'd4}, {1'b1, 1'b0, 3'd5}, {1'b0, 1'b1, 3'd6},
        {1'b1, 1'b1, 3'd1}, {1'b0, 1'b0, 3'd1}, {1'b0, 1'b1, 3'd2}
    };

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(2);
        do_reset();
        // reset state, bridge disabled
        check("R1 tristate at reset", tristate, 1);
        check("R1 drivers off", {high_on, low_on}, 0);
        check("R12 reset position", phase, 1);
        check("R7 stuck_ok reset", stuck_ok, 1);
        check("R8 rev_fault reset", rev_fault, 0);

        out_en = 1'b1; cyc(1);
        check("R2 brake in hold", brake, 1);
        check("R2 lows on", {high_on, low_on}, 6'b000_111);

        // automatic start, dly_sel=0: T1=2, T2=6
        run_brake = 1'b1; cyc(1);
        check("R3 align1 position", phase, 1);
        check("R3 align flag low", align_flag, 0);
        check("R12 pair pos1", {high_on, low_on}, exp_pair(1));
        seq_inc = 1'b1; cyc(1); seq_inc = 1'b0; cyc(1);
        check("R3 seq_inc ignored", phase, 1);
        ref_pulses(1);
        check("R4 before T1", phase, 1);
        ref_pulses(1); cyc(1);
        check("R4 position 3", phase, 3);
        check("R4 align flag", align_flag, 1);
        check("R12 pair pos3", {high_on, low_on}, exp_pair(3));
        ref_pulses(5); cyc(1);
        check("R5 before T2", go_flag, 0);
        ref_pulses(1); cyc(1);
        check("R5 position 5", phase, 5);
        check("R5 go flag", go_flag, 1);

        // closed-loop stepping and slowdown supervision
        zc_pulse();
        check("R6 zc step", phase, 6);
        cyc(8);
        zc_pulse();
        check("R6 wrap", phase, 1);
        cyc(15);
        check("R8 within tolerance", rev_fault, 0);
        check("R8 still go", go_flag, 1);
        cyc(15);
        check("R8 slowdown flag", rev_fault, 1);
        check("R8 brake forced", brake, 1);
        run_brake = 1'b0; cyc(2);
        check("R2 hold brake", {high_on, low_on}, 6'b000_111);

        // second start, dly_sel=1: T1=4, T2=12; then stuck timeout
        dly_sel = 2'd1;
        run_brake = 1'b1; cyc(1);
        check("R8 flag cleared on start", rev_fault, 0);
        ref_pulses(3); cyc(1);
        check("R4 dsel1 before T1", phase, 1);
        ref_pulses(1); cyc(1);
        check("R4 dsel1 position 3", phase, 3);
        ref_pulses(12); cyc(1);
        check("R5 dsel1 go", go_flag, 1);
        cyc(50);
        check("R7 not yet stuck", stuck_ok, 1);
        cyc(60);
        check("R7 stuck flag", stuck_ok, 0);
        check("R7 floated", tristate, 1);
        check("R7 drivers off", {high_on, low_on}, 0);
        cyc(5);
        check("R7 stuck held", tristate, 1);
        run_brake = 1'b0; cyc(2);
        check("R7 exit to brake", brake, 1);

        // disable auto start via seq_inc in hold-and-wait
        out_en = 1'b0; seq_inc = 1'b1; cyc(1); seq_inc = 1'b0; cyc(1);
        out_en = 1'b1; cyc(1);
        run_brake = 1'b1; cyc(1);
        check("R9 no alignment", align_flag, 0);
        check("R9 not braking", brake, 0);
        seq_reset = 1'b1; cyc(1); seq_reset = 1'b0;
        check("R11 seq reset", phase, 1);
        for (int i = 0; i < 12; i++) begin
            seq_inc = EXT_VEC[i][4]; zc_evt = EXT_VEC[i][3];
            cyc(1);
            check("R10 manual step", phase, int'(EXT_VEC[i][2:0]));
            check("R12 pair table", {high_on, low_on}, exp_pair(int'(EXT_VEC[i][2:0])));
        end
        seq_inc = 1'b0; zc_evt = 1'b0; cyc(1);
        seq_reset = 1'b1; zc_evt = 1'b1; cyc(1); seq_reset = 1'b0; zc_evt = 1'b0;
        check("R11 reset beats step", phase, 1);
        out_en = 1'b0; cyc(1);
        check("R1 enable low floats", tristate, 1);
        out_en = 1'b1; cyc(1);
        check("R1 back to hold", brake, 1);

        // auto_mode cleared selects manual path
        run_brake = 1'b0; out_en = 1'b0;
        do_reset();
        auto_mode = 1'b0; out_en = 1'b1; cyc(1);
        run_brake = 1'b1; cyc(1);
        check("R9 auto off no align", align_flag, 0);
        seq_inc = 1'b1; cyc(1); seq_inc = 1'b0; cyc(1);
        check("R9 auto off manual step", phase, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule